// File: doc/BRIEF.md
# CAN Error and Status Register

This block is the CPU-visible error and status word of a CAN controller. Each cycle it takes in what the protocol engine reports: the two error counters, six error-detection strobes, the idle, direction and fault-confinement states, and the bus-off and wake-up events. It combines these into one 32-bit word. Part of the word is live status. Part of it is made of latched error bits, which clear when the word is read. The rest is five sticky interrupt flags, which software clears by writing 1.

The CPU uses a simple one-word port: `bus_rd`/`bus_wr` with an address and write data. The word answers only at offset 0x20. A read that hits is answered one clock later with `bus_rvalid` and the captured word. The access sequencer has two states. `ACC_IDLE` moves to `ACC_RESP` on a read hit. `ACC_RESP` stays in `ACC_RESP` on a further read hit and otherwise returns to `ACC_IDLE`. `bus_rvalid` is high exactly in `ACC_RESP`.

The two warning flags fire on edges. Each one sets only when its error counter first reaches 96 or more while warning reporting is enabled. Each of the five flags drives its own interrupt output through an external mask.

Top module: `can_esr_reg`

## Requirements
- R1: After reset every bit of the word is 0, `bus_rvalid` is 0 and all five interrupt outputs are 0.
- R2: A read with `bus_addr` = 0x20 gives `bus_rvalid` = 1 and the word in `bus_rdata` one clock later. The word returned is its value before that clock edge. A read at any other address gives no `bus_rvalid`.
- R3: Bits 31:18 and bit 3 always read 0. Writing 1 to any bit other than 17, 16, 2, 1 and 0 changes nothing.
- R4: Bit 17 (transmit warning flag) sets only when `warn_irq_enable` is 1 and the transmit counter goes from below 96 to 96 or more. A counter that is already high when reporting is enabled, or one that stays high, does not set it.
- R5: Bit 16 (receive warning flag) follows the R4 rule using the receive counter.
- R6: Bit 9 reads 1 exactly while the transmit counter is at least 96. Bit 8 does the same for the receive counter.
- R7: Writing 1 to bit 17, 16, 2, 1 or 0 clears that flag. Writing 0 leaves it unchanged.
- R8: When a set event and a write-1 clear hit the same flag in the same cycle, the flag stays set.
- R9: Bits 15..10 (bit-1, bit-0, ACK, CRC, form, stuff error) latch on their strobes. A read returns them and clears them, unless a strobe fires in the same cycle as the read.
- R10: A bit-1 strobe is ignored while `in_arb_field`, `in_ack_slot` or `passive_eflag` is 1. It then sets neither bit 15 nor bit 1.
- R11: Bit 1 (error flag) sets whenever any accepted error strobe fires.
- R12: Bit 2 (bus-off flag) sets on `boff_evt`. Bit 0 (wake-up flag) sets on `wak_evt`.
- R13: Each interrupt output is high exactly while its flag is 1 and its mask input is 1.
- R14: Bit 7 shows `bus_idle`, bit 6 shows `txrx_state` and bits 5:4 show `conf_state`, all live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_rd | input | 1 | Read request |
| bus_wr | input | 1 | Write request |
| bus_addr | input | ADDR_W (8) | Byte offset of the access |
| bus_wdata | input | 32 | Write data (1 clears a flag) |
| bus_rdata | output | 32 | Captured read word |
| bus_rvalid | output | 1 | Read response valid |
| tx_err_cnt | input | CNT_W (8) | Transmit error counter |
| rx_err_cnt | input | CNT_W (8) | Receive error counter |
| warn_irq_enable | input | 1 | Enables the warning flags |
| tx_warn_mask | input | 1 | Mask for the transmit warning interrupt |
| rx_warn_mask | input | 1 | Mask for the receive warning interrupt |
| busoff_mask | input | 1 | Mask for the bus-off interrupt |
| error_mask | input | 1 | Mask for the error interrupt |
| wakeup_mask | input | 1 | Mask for the wake-up interrupt |
| bit1_err_stb | input | 1 | Recessive bit sent, dominant seen |
| bit0_err_stb | input | 1 | Dominant bit sent, recessive seen |
| ack_err_stb | input | 1 | Acknowledge error |
| crc_err_stb | input | 1 | CRC error |
| form_err_stb | input | 1 | Form error |
| stuff_err_stb | input | 1 | Stuffing error |
| in_arb_field | input | 1 | Engine is in the arbitration field |
| in_ack_slot | input | 1 | Engine is in the ACK slot |
| passive_eflag | input | 1 | Node is sending a passive error flag |
| bus_idle | input | 1 | Bus idle state |
| txrx_state | input | 1 | Transmitting (1) or receiving (0) |
| conf_state | input | 2 | Fault-confinement state |
| boff_evt | input | 1 | Bus-off entry event |
| wak_evt | input | 1 | Wake-up event |
| irq_tx_warn | output | 1 | Transmit warning interrupt |
| irq_rx_warn | output | 1 | Receive warning interrupt |
| irq_busoff | output | 1 | Bus-off interrupt |
| irq_error | output | 1 | Error interrupt |
| irq_wakeup | output | 1 | Wake-up interrupt |

## Verification
Results arrive at different times:
- Live fields (bits 9, 8, 7, 6, 5:4) and the interrupt outputs follow their inputs within the same cycle.
- A flag or error bit reflects an event one edge after the event's cycle.
- A read returns its word one edge after the request.

The bench drives all inputs on the falling edge. It then lets exactly the number of rising edges that the result needs go by, and samples on the next falling edge, so every comparison lands in the cycle where the value is due. Edge-detection cases, such as the counter staying high or reporting being enabled late, are checked by reading back after each step.

// File: rtl/can_esr_pkg.sv
package can_esr_pkg;
    localparam int ESR_W      = 32;
    localparam int ERR_N      = 6;
    localparam int FLAG_N     = 5;

    // flag vector indices
    localparam int F_WAK      = 0;
    localparam int F_ERR      = 1;
    localparam int F_BOFF     = 2;
    localparam int F_RXW      = 3;
    localparam int F_TXW      = 4;

    // bit positions inside the status word
    localparam int P_WAK      = 0;
    localparam int P_ERRF     = 1;
    localparam int P_BOFF     = 2;
    localparam int P_CONF_LO  = 4;
    localparam int P_TXRX     = 6;
    localparam int P_IDLE     = 7;
    localparam int P_RXW_S    = 8;
    localparam int P_TXW_S    = 9;
    localparam int P_ERR_LO   = 10;
    localparam int P_RXW_F    = 16;
    localparam int P_TXW_F    = 17;

    // error vector index 5 is the bit-1 error
    localparam int E_BIT1     = 5;

    typedef enum logic [0:0] {
        ACC_IDLE = 1'b0,
        ACC_RESP = 1'b1
    } acc_state_t;
endpackage

// File: rtl/can_esr_warn.sv
module can_esr_warn #(
    parameter int CNT_W    = 8,
    parameter int WARN_LVL = 96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic             enable,
    output logic             level,
    output logic             rise
);
    localparam logic [CNT_W-1:0] LVL = CNT_W'(WARN_LVL);

    logic level_q;

    assign level = (cnt >= LVL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level;
    end

    // edge of the level, counted only while reporting is on
    assign rise = enable && level && !level_q;
endmodule

// File: rtl/can_esr_errcap.sv
module can_esr_errcap #(
    parameter int ERR_N = 6,
    parameter int BIT1  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_N-1:0] stb,
    input  logic             bit1_block,
    input  logic             rd_clr,
    output logic [ERR_N-1:0] stat,
    output logic             any_hit
);
    logic [ERR_N-1:0] qual;

    always_comb begin
        qual       = stb;
        qual[BIT1] = stb[BIT1] && !bit1_block;
    end

    assign any_hit = |qual;

    for (genvar i = 0; i < ERR_N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stat[i] <= 1'b0;
            else        stat[i] <= qual[i] || (stat[i] && !rd_clr);
        end
    end
endmodule

// File: rtl/can_esr_sticky.sv
module can_esr_sticky #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q[i] <= 1'b0;
            else        q[i] <= set[i] || (q[i] && !clr[i]);
        end
    end
endmodule

// File: rtl/can_esr_reg.sv
module can_esr_reg
    import can_esr_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int REG_OFFSET = 32'h20,
    parameter int CNT_W      = 8,
    parameter int WARN_LVL   = 96
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    input  logic [CNT_W-1:0]  tx_err_cnt,
    input  logic [CNT_W-1:0]  rx_err_cnt,
    input  logic              warn_irq_enable,
    input  logic              tx_warn_mask,
    input  logic              rx_warn_mask,
    input  logic              busoff_mask,
    input  logic              error_mask,
    input  logic              wakeup_mask,
    input  logic              bit1_err_stb,
    input  logic              bit0_err_stb,
    input  logic              ack_err_stb,
    input  logic              crc_err_stb,
    input  logic              form_err_stb,
    input  logic              stuff_err_stb,
    input  logic              in_arb_field,
    input  logic              in_ack_slot,
    input  logic              passive_eflag,
    input  logic              bus_idle,
    input  logic              txrx_state,
    input  logic [1:0]        conf_state,
    input  logic              boff_evt,
    input  logic              wak_evt,
    output logic              irq_tx_warn,
    output logic              irq_rx_warn,
    output logic              irq_busoff,
    output logic              irq_error,
    output logic              irq_wakeup
);
    localparam logic [ADDR_W-1:0] OFF = ADDR_W'(REG_OFFSET);
    localparam int                NW  = 2;   // transmit and receive

    acc_state_t         state_q, state_d;
    logic               hit, rd_hit, wr_hit;
    logic [CNT_W-1:0]   cnt_v   [NW];
    logic [NW-1:0]      wlevel, wrise;
    logic [ERR_N-1:0]   err_stb, err_stat;
    logic               err_any;
    logic [FLAG_N-1:0]  flag_set, flag_clr, flag_q;
    logic [ESR_W-1:0]   word;
    logic [ESR_W-1:0]   rdata_q;
    logic               unused_ok;

    assign hit    = (bus_addr == OFF);
    assign rd_hit = bus_rd && hit;
    assign wr_hit = bus_wr && hit;

    // warning level detectors, index 0 transmit, index 1 receive
    assign cnt_v[0] = tx_err_cnt;
    assign cnt_v[1] = rx_err_cnt;

    for (genvar w = 0; w < NW; w++) begin : g_warn
        can_esr_warn #(
            .CNT_W    (CNT_W),
            .WARN_LVL (WARN_LVL)
        ) u_warn (
            .clk    (clk),
            .rst_n  (rst_n),
            .cnt    (cnt_v[w]),
            .enable (warn_irq_enable),
            .level  (wlevel[w]),
            .rise   (wrise[w])
        );
    end

    // error capture, ordered as in bits 15..10
    assign err_stb = {bit1_err_stb, bit0_err_stb, ack_err_stb,
                      crc_err_stb, form_err_stb, stuff_err_stb};

    can_esr_errcap #(
        .ERR_N (ERR_N),
        .BIT1  (E_BIT1)
    ) u_errcap (
        .clk        (clk),
        .rst_n      (rst_n),
        .stb        (err_stb),
        .bit1_block (in_arb_field || in_ack_slot || passive_eflag),
        .rd_clr     (rd_hit),
        .stat       (err_stat),
        .any_hit    (err_any)
    );

    // sticky interrupt flags
    always_comb begin
        flag_set         = '0;
        flag_set[F_WAK]  = wak_evt;
        flag_set[F_ERR]  = err_any;
        flag_set[F_BOFF] = boff_evt;
        flag_set[F_RXW]  = wrise[1];
        flag_set[F_TXW]  = wrise[0];

        flag_clr         = '0;
        if (wr_hit) begin
            flag_clr[F_WAK]  = bus_wdata[P_WAK];
            flag_clr[F_ERR]  = bus_wdata[P_ERRF];
            flag_clr[F_BOFF] = bus_wdata[P_BOFF];
            flag_clr[F_RXW]  = bus_wdata[P_RXW_F];
            flag_clr[F_TXW]  = bus_wdata[P_TXW_F];
        end
    end

    can_esr_sticky #(
        .N (FLAG_N)
    ) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   (flag_clr),
        .q     (flag_q)
    );

    // status word assembly
    always_comb begin
        word                           = '0;
        word[P_TXW_F]                  = flag_q[F_TXW];
        word[P_RXW_F]                  = flag_q[F_RXW];
        word[P_ERR_LO +: ERR_N]        = err_stat;
        word[P_TXW_S]                  = wlevel[0];
        word[P_RXW_S]                  = wlevel[1];
        word[P_IDLE]                   = bus_idle;
        word[P_TXRX]                   = txrx_state;
        word[P_CONF_LO +: 2]           = conf_state;
        word[P_BOFF]                   = flag_q[F_BOFF];
        word[P_ERRF]                   = flag_q[F_ERR];
        word[P_WAK]                    = flag_q[F_WAK];
    end

    // access sequencer: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE: if (rd_hit) state_d = ACC_RESP;
            ACC_RESP: state_d = rd_hit ? ACC_RESP : ACC_IDLE;
        endcase
    end

    // read data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_hit) rdata_q <= word;
    end

    // outputs
    always_comb begin
        bus_rvalid  = (state_q == ACC_RESP);
        bus_rdata   = rdata_q;
        irq_tx_warn = flag_q[F_TXW]  && tx_warn_mask;
        irq_rx_warn = flag_q[F_RXW]  && rx_warn_mask;
        irq_busoff  = flag_q[F_BOFF] && busoff_mask;
        irq_error   = flag_q[F_ERR]  && error_mask;
        irq_wakeup  = flag_q[F_WAK]  && wakeup_mask;
    end

    // write data bits that carry no clear
    assign unused_ok = ^{bus_wdata[31:18], bus_wdata[15:3]};
endmodule

// File: rtl/can_esr_chk.sv
module can_esr_chk #(
    parameter int ADDR_W     = 8,
    parameter int REG_OFFSET = 32'h20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              bus_rvalid,
    input logic              warn_irq_enable,
    input logic              bit1_err_stb,
    input logic              in_arb_field,
    input logic              in_ack_slot,
    input logic              passive_eflag,
    input logic              wak_evt,
    input logic              boff_evt,
    input logic              tx_warn_mask,
    input logic              irq_tx_warn,
    input logic [4:0]        flag_q,
    input logic [5:0]        err_stat
);
    localparam logic [ADDR_W-1:0] OFF = ADDR_W'(REG_OFFSET);

    // R2
    rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFF) |=> bus_rvalid);

    // R2
    rd_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_addr == OFF) |=> !bus_rvalid);

    // R3
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> (bus_rdata[31:18] == 14'd0 && !bus_rdata[3]));

    // R4
    txw_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[4]) |-> $past(warn_irq_enable));

    // R5
    rxw_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[3]) |-> $past(warn_irq_enable));

    // R8
    wak_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wak_evt |=> flag_q[0]);

    // R12
    boff_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boff_evt |=> flag_q[2]);

    // R10
    bit1_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_stat[5]) |->
            $past(bit1_err_stb && !in_arb_field && !in_ack_slot && !passive_eflag));

    // R13
    irq_txw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx_warn |-> (flag_q[4] && tx_warn_mask));
endmodule

bind can_esr_reg can_esr_chk #(
    .ADDR_W     (ADDR_W),
    .REG_OFFSET (REG_OFFSET)
) i_esr_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_rd          (bus_rd),
    .bus_addr        (bus_addr),
    .bus_rdata       (bus_rdata),
    .bus_rvalid      (bus_rvalid),
    .warn_irq_enable (warn_irq_enable),
    .bit1_err_stb    (bit1_err_stb),
    .in_arb_field    (in_arb_field),
    .in_ack_slot     (in_ack_slot),
    .passive_eflag   (passive_eflag),
    .wak_evt         (wak_evt),
    .boff_evt        (boff_evt),
    .tx_warn_mask    (tx_warn_mask),
    .irq_tx_warn     (irq_tx_warn),
    .flag_q          (flag_q),
    .err_stat        (err_stat)
);

// File: tb/test_can_esr_reg.sv
`timescale 1ns/1ps
module test_can_esr_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 0, bus_wr = 0;
    logic [7:0]  bus_addr = 8'h20;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [7:0]  tx_err_cnt = 0, rx_err_cnt = 0;
    logic        warn_irq_enable = 0;
    logic        tx_warn_mask = 0, rx_warn_mask = 0, busoff_mask = 0,
                 error_mask = 0, wakeup_mask = 0;
    logic        bit1_err_stb = 0, bit0_err_stb = 0, ack_err_stb = 0,
                 crc_err_stb = 0, form_err_stb = 0, stuff_err_stb = 0;
    logic        in_arb_field = 0, in_ack_slot = 0, passive_eflag = 0;
    logic        bus_idle = 0, txrx_state = 0;
    logic [1:0]  conf_state = 0;
    logic        boff_evt = 0, wak_evt = 0;
    logic        irq_tx_warn, irq_rx_warn, irq_busoff, irq_error, irq_wakeup;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;   // 50 MHz

    can_esr_reg i_can_esr_reg (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd_word(input logic [7:0] a, output logic [31:0] v, output logic vld);
        @(negedge clk); bus_rd = 1; bus_addr = a;
        @(negedge clk); bus_rd = 0; bus_addr = 8'h20;
        v = bus_rdata; vld = bus_rvalid;
    endtask

    task automatic read_expect(input string req, input logic [31:0] exp);
        logic [31:0] v; logic vld;
        rd_word(8'h20, v, vld);
        check("R2 rvalid", {31'd0, vld}, 32'd1);
        check(req, v, exp);
    endtask

    task automatic wr_word(input logic [31:0] d);
        @(negedge clk); bus_wr = 1; bus_wdata = d;
        @(negedge clk); bus_wr = 0; bus_wdata = '0;
    endtask

    task automatic t_reset;
        check("R1 rvalid", {31'd0, bus_rvalid}, 32'd0);
        check("R1 irqs", {27'd0, irq_tx_warn, irq_rx_warn, irq_busoff, irq_error, irq_wakeup}, 32'd0);
        read_expect("R1 word", 32'h0);
    endtask

    task automatic t_live;
        logic [31:0] v; logic vld;
        @(negedge clk); bus_idle = 1; txrx_state = 1; conf_state = 2'b10;
        read_expect("R14 live a", 32'h0000_00E0);
        @(negedge clk); bus_idle = 0; txrx_state = 0; conf_state = 2'b01;
        read_expect("R14 live b", 32'h0000_0010);
        @(negedge clk); conf_state = 2'b00;
        rd_word(8'h24, v, vld);
        check("R2 miss", {31'd0, vld}, 32'd0);
    endtask

    task automatic t_tx_warn;
        @(negedge clk); warn_irq_enable = 1; tx_err_cnt = 95;
        read_expect("R6 below", 32'h0);
        @(negedge clk); tx_err_cnt = 96;
        @(negedge clk);
        check("R13 masked", {31'd0, irq_tx_warn}, 32'd0);
        tx_warn_mask = 1; #1;
        check("R13 unmasked", {31'd0, irq_tx_warn}, 32'd1);
        read_expect("R4 rise", 32'h0002_0200);
        wr_word(32'h0002_0000);
        check("R13 cleared", {31'd0, irq_tx_warn}, 32'd0);
        read_expect("R4 held high no reset", 32'h0000_0200);
        @(negedge clk); tx_err_cnt = 10;
        read_expect("R6 drop", 32'h0);
        @(negedge clk); warn_irq_enable = 0; tx_err_cnt = 120;
        read_expect("R4 disabled", 32'h0000_0200);
        @(negedge clk); warn_irq_enable = 1;
        read_expect("R4 late enable", 32'h0000_0200);
        @(negedge clk); tx_err_cnt = 0; tx_warn_mask = 0;
    endtask

    task automatic t_rx_warn;
        @(negedge clk); rx_err_cnt = 200;
        @(negedge clk); rx_warn_mask = 1; #1;
        check("R13 rx irq", {31'd0, irq_rx_warn}, 32'd1);
        read_expect("R5 rise", 32'h0001_0100);
        wr_word(32'h0001_0000);
        read_expect("R5 cleared", 32'h0000_0100);
        @(negedge clk); rx_err_cnt = 0; rx_warn_mask = 0;
    endtask

    task automatic pulse_boff;
        @(negedge clk); boff_evt = 1;
        @(negedge clk); boff_evt = 0;
    endtask

    task automatic t_w1c;
        pulse_boff();
        busoff_mask = 1; #1;
        check("R13 busoff irq", {31'd0, irq_busoff}, 32'd1);
        read_expect("R12 busoff", 32'h0000_0004);
        wr_word(32'h0);
        read_expect("R7 write 0", 32'h0000_0004);
        wr_word(32'hFFFF_FFFB);
        read_expect("R3 read-only", 32'h0000_0004);
        wr_word(32'h0000_0004);
        read_expect("R7 write 1", 32'h0);
        busoff_mask = 0;
    endtask

    task automatic t_set_wins;
        @(negedge clk); wakeup_mask = 1; wak_evt = 1; bus_wr = 1; bus_wdata = 32'h1;
        @(negedge clk); wak_evt = 0; bus_wr = 0; bus_wdata = 0;
        check("R8 set wins", {31'd0, irq_wakeup}, 32'd1);
        read_expect("R12 wake", 32'h0000_0001);
        wr_word(32'h1);
        check("R7 wake clear", {31'd0, irq_wakeup}, 32'd0);
        wakeup_mask = 0;
    endtask

    task automatic t_errors;
        @(negedge clk); ack_err_stb = 1;
        @(negedge clk); ack_err_stb = 0; error_mask = 1; #1;
        check("R13 error irq", {31'd0, irq_error}, 32'd1);
        read_expect("R9 ack latched R11", 32'h0000_2002);
        read_expect("R9 read clears", 32'h0000_0002);
        @(negedge clk); crc_err_stb = 1; stuff_err_stb = 1;
        @(negedge clk); crc_err_stb = 0; stuff_err_stb = 0;
        read_expect("R9 crc stuff", 32'h0000_1402);
        wr_word(32'h2);
        read_expect("R7 error clear", 32'h0);
        error_mask = 0;
    endtask

    task automatic bit1_pulse(input logic arb, input logic ack, input logic pas);
        @(negedge clk); bit1_err_stb = 1; in_arb_field = arb; in_ack_slot = ack; passive_eflag = pas;
        @(negedge clk); bit1_err_stb = 0; in_arb_field = 0; in_ack_slot = 0; passive_eflag = 0;
    endtask

    task automatic t_bit1;
        bit1_pulse(1, 0, 0);
        read_expect("R10 arbitration", 32'h0);
        bit1_pulse(0, 1, 0);
        read_expect("R10 ack slot", 32'h0);
        bit1_pulse(0, 0, 1);
        read_expect("R10 passive flag", 32'h0);
        bit1_pulse(0, 0, 0);
        read_expect("R10 accepted R11", 32'h0000_8002);
        wr_word(32'h2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_live();
        t_tx_warn();
        t_rx_warn();
        t_w1c();
        t_set_wins();
        t_errors();
        t_bit1();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule